// File: doc/BRIEF.md
# Host-to-Local Address Window Remapper

This block sits between a host-facing firmware-space bus and a local system bus. It moves one programmable window. A 32-bit host address comes in on the translate path. If the address falls inside the window and the window is enabled, the block raises a hit flag and returns the local system-bus address that replaces it. The translate path is combinational. Only the upper 16 address bits are remapped. The lower 16 bits always pass through unchanged, so window sizes and offsets come in multiples of 64 KiB.

Software sets the window through a small register port with four registers, selected by index: 0 = base, 1 = mask, 2 = control, 3 = mode. The base register holds the local target bits in its upper half and the host-side window bits in its lower half. In the mask register, the upper half marks the host bits to discard and replace with local base bits. The lower half marks the host bits that are kept. For a power-of-two window of size S, software writes ~(S-1) to the mask's upper half and (S>>16)-1 to its lower half, and picks a host offset that is a multiple of S.

The mode register combines two things. One is a read/write switch bit. The others are event status flags, which input pulses set and which software clears by writing 1. A write that carries only the switch bit therefore leaves the flags alone.

Top module: `hwin_remap`

## Requirements
- R1: After synchronous reset all four registers read as zero, `hit` is 0 and `local_addr` is 0.
- R2: When `rd_en` is high at a clock edge, `rd_data` shows the register picked by `rd_sel` (0 base, 1 mask, 2 control, 3 mode), as it was before that edge, from the next cycle on. Otherwise `rd_data` holds its value.
- R3: A write with `wr_sel` 0, 1 or 2 stores all 32 bits of `wr_data` into base, mask or control.
- R4: On a hit, `local_addr[31:16]` = (host[31:16] & mask[15:0]) | (base[31:16] & mask[31:16]), and `local_addr[15:0]` = host[15:0].
- R5: The window matches when (host[31:16] & mask[31:16]) equals (base[15:0] & mask[31:16]).
- R6: `hit` can be 1 only while control bit 10 (firmware-cycle enable) and control bit 8 (host-to-local enable) are both 1. With either bit clear, `hit` is 0.
- R7: Whenever `hit` is 0, `local_addr` is 0.
- R8: A write to mode bit 17 (the switch) loads `wr_data[17]` into it. Every other mode bit is cleared where `wr_data` has a 1 and keeps its value where `wr_data` has a 0.
- R9: A pulse on `evt_i[k]`, for k not equal to 17, sets mode bit k at the next edge. `evt_i[17]` has no effect.
- R10: If an event pulse and a write-1 clear hit the same mode bit in the same cycle, the bit ends up set.
- R11: With a 1 MiB window (mask 0xFFF0_000F) and base 0x8400_0E00, host address 0x0E05_1234 maps to 0x8405_1234, and host address 0x0E15_0000 misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register index for writes |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_sel | input | 2 | Register index for reads |
| rd_data | output | 32 | Registered read data |
| evt_i | input | 32 | Status event pulses, one per mode bit (bit 17 ignored) |
| host_addr | input | 32 | Host firmware-space address to translate |
| hit | output | 1 | Address falls inside the enabled window |
| local_addr | output | 32 | Translated local address, zero on a miss |

## Verification
A corrupted base or mask bit appears on `local_addr` or `hit` in the same cycle that a host address exercises that bit. A stuck enable bit shows as a hit that should not exist, or a missing one. A wrong status flag does not reach the outputs until software reads the mode register, so the bench reads it back one cycle after every event or write. The reference model is compared against every output on every clock, so any divergence is reported within one cycle of the first visible difference.

// File: rtl/hwr_pkg.sv
package hwr_pkg;
  localparam int unsigned REG_SEL_W = 2;

  typedef enum logic [REG_SEL_W-1:0] {
    SEL_BASE = 2'd0,
    SEL_MASK = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_MODE = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/hwr_cfg_regs.sv
module hwr_cfg_regs
  import hwr_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]        wr_data,
  output logic [AW-1:0]        base_q,
  output logic [AW-1:0]        mask_q,
  output logic [AW-1:0]        ctrl_q
);
  logic [AW-1:0] cfg_q [3];

  for (genvar g = 0; g < 3; g++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (rst) begin
        cfg_q[g] <= '0;
      end else if (wr_en && (wr_sel == REG_SEL_W'(g))) begin
        cfg_q[g] <= wr_data;
      end
    end
  end

  assign base_q = cfg_q[SEL_BASE];
  assign mask_q = cfg_q[SEL_MASK];
  assign ctrl_q = cfg_q[SEL_CTRL];
endmodule

// File: rtl/hwr_mode_stat.sv
module hwr_mode_stat
  import hwr_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned SW_BIT = 17
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_mode,
  input  logic [AW-1:0] wr_data,
  input  logic [AW-1:0] evt_i,
  output logic [AW-1:0] mode_q
);
  logic unused_sw_evt;
  assign unused_sw_evt = evt_i[SW_BIT];

  for (genvar b = 0; b < AW; b++) begin : g_bit
    if (b == SW_BIT) begin : g_switch
      always_ff @(posedge clk) begin
        if (rst)          mode_q[b] <= 1'b0;
        else if (wr_mode) mode_q[b] <= wr_data[b];
      end
    end else begin : g_flag
      logic clr;
      assign clr = wr_mode & wr_data[b];
      always_ff @(posedge clk) begin
        if (rst)           mode_q[b] <= 1'b0;
        else if (evt_i[b]) mode_q[b] <= 1'b1;
        else if (clr)      mode_q[b] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/hwr_xlate.sv
module hwr_xlate #(
  parameter int unsigned AW        = 32,
  parameter int unsigned EN_FW_BIT = 10,
  parameter int unsigned EN_HL_BIT = 8
) (
  input  logic [AW-1:0] host_addr,
  input  logic [AW-1:0] base_q,
  input  logic [AW-1:0] mask_q,
  input  logic [AW-1:0] ctrl_q,
  output logic          hit,
  output logic [AW-1:0] local_addr
);
  localparam int unsigned HW = AW / 2;

  logic [HW-1:0] host_hi, repl_m, keep_m, loc_base, win_base, new_hi;
  logic          enabled, match;
  logic [AW-1:0] ctrl_rest;
  logic          unused_ctrl;

  assign host_hi  = host_addr[AW-1:HW];
  assign repl_m   = mask_q[AW-1:HW];
  assign keep_m   = mask_q[HW-1:0];
  assign loc_base = base_q[AW-1:HW];
  assign win_base = base_q[HW-1:0];

  always_comb begin
    ctrl_rest = ctrl_q;
    ctrl_rest[EN_FW_BIT] = 1'b0;
    ctrl_rest[EN_HL_BIT] = 1'b0;
  end
  assign unused_ctrl = |ctrl_rest;

  assign enabled = ctrl_q[EN_FW_BIT] & ctrl_q[EN_HL_BIT];
  assign match   = (host_hi & repl_m) == (win_base & repl_m);
  assign new_hi  = (host_hi & keep_m) | (loc_base & repl_m);
  assign hit     = enabled & match;

  always_comb begin
    if (hit) local_addr = {new_hi, host_addr[HW-1:0]};
    else     local_addr = '0;
  end
endmodule

// File: rtl/hwin_remap.sv
module hwin_remap
  import hwr_pkg::*;
#(
  parameter int unsigned AW        = 32,
  parameter int unsigned EN_FW_BIT = 10,
  parameter int unsigned EN_HL_BIT = 8,
  parameter int unsigned SW_BIT    = 17
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [REG_SEL_W-1:0] wr_sel,
  input  logic [AW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [REG_SEL_W-1:0] rd_sel,
  output logic [AW-1:0]        rd_data,
  input  logic [AW-1:0]        evt_i,
  input  logic [AW-1:0]        host_addr,
  output logic                 hit,
  output logic [AW-1:0]        local_addr
);
  logic [AW-1:0] base_q, mask_q, ctrl_q, mode_q;
  logic          wr_mode;
  logic [AW-1:0] rd_mux;

  assign wr_mode = wr_en && (wr_sel == SEL_MODE);

  hwr_cfg_regs #(.AW(AW)) u_cfg (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .base_q(base_q), .mask_q(mask_q), .ctrl_q(ctrl_q)
  );

  hwr_mode_stat #(.AW(AW), .SW_BIT(SW_BIT)) u_mode (
    .clk(clk), .rst(rst), .wr_mode(wr_mode), .wr_data(wr_data),
    .evt_i(evt_i), .mode_q(mode_q)
  );

  hwr_xlate #(.AW(AW), .EN_FW_BIT(EN_FW_BIT), .EN_HL_BIT(EN_HL_BIT)) u_xl (
    .host_addr(host_addr), .base_q(base_q), .mask_q(mask_q), .ctrl_q(ctrl_q),
    .hit(hit), .local_addr(local_addr)
  );

  always_comb begin
    unique case (rd_sel)
      SEL_BASE: rd_mux = base_q;
      SEL_MASK: rd_mux = mask_q;
      SEL_CTRL: rd_mux = ctrl_q;
      default:  rd_mux = mode_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end
endmodule

// File: rtl/hwin_remap_chk.sv
module hwin_remap_chk #(
  parameter int unsigned AW        = 32,
  parameter int unsigned EN_FW_BIT = 10,
  parameter int unsigned EN_HL_BIT = 8,
  parameter int unsigned SW_BIT    = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          wr_en,
  input logic [1:0]    wr_sel,
  input logic [AW-1:0] evt_i,
  input logic [AW-1:0] host_addr,
  input logic          hit,
  input logic [AW-1:0] local_addr,
  input logic [AW-1:0] base_q,
  input logic [AW-1:0] ctrl_q,
  input logic [AW-1:0] mode_q
);
  localparam logic [AW-1:0] FLAG_M = ~(AW'(1) << SW_BIT);

  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (base_q == '0 && ctrl_q == '0 && mode_q == '0));

  a_r4_low_pass: assert property (@(posedge clk) disable iff (rst)
    hit |-> (local_addr[AW/2-1:0] == host_addr[AW/2-1:0]));

  a_r6_needs_both_enables: assert property (@(posedge clk) disable iff (rst)
    hit |-> (ctrl_q[EN_FW_BIT] && ctrl_q[EN_HL_BIT]));

  a_r7_miss_zero: assert property (@(posedge clk) disable iff (rst)
    !hit |-> (local_addr == '0));

  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    ((evt_i & FLAG_M) != '0) |=> ((mode_q & $past(evt_i & FLAG_M)) == $past(evt_i & FLAG_M)));

  a_r8_mode_quiet: assert property (@(posedge clk) disable iff (rst)
    (!(wr_en && wr_sel == 2'd3) && ((evt_i & FLAG_M) == '0)) |=> $stable(mode_q));
endmodule

bind hwin_remap hwin_remap_chk #(
  .AW(AW), .EN_FW_BIT(EN_FW_BIT), .EN_HL_BIT(EN_HL_BIT), .SW_BIT(SW_BIT)
) u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .evt_i(evt_i),
  .host_addr(host_addr), .hit(hit), .local_addr(local_addr),
  .base_q(base_q), .ctrl_q(ctrl_q), .mode_q(mode_q)
);

// File: tb/test_hwin_remap.sv
module test_hwin_remap;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_sel = 2'd0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_sel = 2'd0;
  logic [31:0] rd_data;
  logic [31:0] evt_i = '0;
  logic [31:0] host_addr = '0;
  logic        hit;
  logic [31:0] local_addr;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  hwin_remap i_hwin_remap (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_sel(rd_sel), .rd_data(rd_data), .evt_i(evt_i),
    .host_addr(host_addr), .hit(hit), .local_addr(local_addr)
  );

  // behavioural reference model
  logic [31:0] m_reg [4];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) m_reg[i] <= '0;
      m_rd <= '0;
    end else begin
      if (rd_en) m_rd <= m_reg[rd_sel];
      for (int i = 0; i < 3; i++)
        if (wr_en && wr_sel == i[1:0]) m_reg[i] <= wr_data;
      begin
        logic [31:0] nm;
        nm = m_reg[3];
        if (wr_en && wr_sel == 2'd3) begin
          nm = nm & ~(wr_data & 32'hFFFD_FFFF);
          nm[17] = wr_data[17];
        end
        nm = nm | (evt_i & 32'hFFFD_FFFF);
        m_reg[3] <= nm;
      end
    end
  end

  function automatic void model_xl(input logic [31:0] h, output logic eh, output logic [31:0] el);
    logic [15:0] hh, rm, km, lb, wb;
    hh = h[31:16]; rm = m_reg[1][31:16]; km = m_reg[1][15:0];
    lb = m_reg[0][31:16]; wb = m_reg[0][15:0];
    eh = m_reg[2][10] && m_reg[2][8] && ((hh & rm) == (wb & rm));
    el = eh ? {(hh & km) | (lb & rm), h[15:0]} : 32'h0;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // every-clock comparison against the model
  always @(posedge clk) begin
    #2;
    if (!rst && !done) begin
      logic eh;
      logic [31:0] el;
      model_xl(host_addr, eh, el);
      check("R5/R6 hit vs model", {31'b0, hit}, {31'b0, eh});
      check("R4/R7 local_addr vs model", local_addr, el);
      check("R2 rd_data vs model", rd_data, m_rd);
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_sel = s; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk); rd_en = 1'b1; rd_sel = s;
    @(posedge clk); #2; v = rd_data;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic pulse(input logic [31:0] e);
    @(negedge clk); evt_i = e;
    @(negedge clk); evt_i = '0;
  endtask

  task automatic probe(input logic [31:0] h);
    @(negedge clk); host_addr = h;
    #1;
  endtask

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    total++; bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    repeat (3) step();
    rst = 1'b0;
    // R1: reset values
    for (int i = 0; i < 4; i++) begin
      rd(i[1:0], v);
      check("R1 reset register", v, 32'h0);
    end
    probe(32'h0000_0000);
    check("R1 hit after reset", {31'b0, hit}, 32'h0);
    check("R1 local after reset", local_addr, 32'h0);

    // R3: configuration writes, R11 window setup
    wr(2'd0, 32'h8400_0E00);
    wr(2'd1, 32'hFFF0_000F);
    rd(2'd0, v); check("R3 base readback", v, 32'h8400_0E00);
    rd(2'd1, v); check("R3 mask readback", v, 32'hFFF0_000F);

    // R6: enables
    probe(32'h0E05_1234);
    check("R6 disabled no hit", {31'b0, hit}, 32'h0);
    check("R7 disabled zero addr", local_addr, 32'h0);
    wr(2'd2, 32'h0000_0400);
    check("R6 fw-only no hit", {31'b0, hit}, 32'h0);
    wr(2'd2, 32'h0000_0100);
    check("R6 hl-only no hit", {31'b0, hit}, 32'h0);
    wr(2'd2, 32'h0000_0500);
    rd(2'd2, v); check("R3 ctrl readback", v, 32'h0000_0500);

    // R11, R4, R5
    probe(32'h0E05_1234);
    check("R11 in-window hit", {31'b0, hit}, 32'h1);
    check("R11 in-window map", local_addr, 32'h8405_1234);
    probe(32'h0E0F_FFFF);
    check("R4 top of window", local_addr, 32'h840F_FFFF);
    probe(32'h0E15_0000);
    check("R11 outside window miss", {31'b0, hit}, 32'h0);
    check("R7 miss zero", local_addr, 32'h0);
    probe(32'h1E00_0000);
    check("R5 high bit differs miss", {31'b0, hit}, 32'h0);

    // R4: kept bits come from host even when local base has them set
    wr(2'd0, 32'h840F_0E00);
    probe(32'h0E03_00AA);
    check("R4 keep and replace", local_addr, 32'h8403_00AA);

    // R8, R9: mode register
    pulse(32'h0002_0003);
    rd(2'd3, v); check("R9 flags set, evt bit17 ignored", v, 32'h0000_0003);
    wr(2'd3, 32'h0002_0000);
    rd(2'd3, v); check("R8 switch write keeps flags", v, 32'h0002_0003);
    wr(2'd3, 32'h0000_0001);
    rd(2'd3, v); check("R8 w1c clears one flag and switch", v, 32'h0000_0002);
    wr(2'd3, 32'h0000_0000);
    rd(2'd3, v); check("R8 write zero keeps flags", v, 32'h0000_0002);

    // R10: set wins over clear in same cycle
    @(negedge clk);
    wr_en = 1'b1; wr_sel = 2'd3; wr_data = 32'h0002_0006; evt_i = 32'h0000_0002;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; evt_i = '0;
    rd(2'd3, v); check("R10 set beats clear", v, 32'h0002_0002);

    // R2: read holds when rd_en low
    repeat (2) step();
    check("R2 rd_data holds", rd_data, 32'h0002_0002);

    // R1: reset again mid-run
    @(negedge clk); rst = 1'b1;
    repeat (2) step();
    rst = 1'b0;
    rd(2'd3, v); check("R1 mode cleared by reset", v, 32'h0);
    probe(32'h0E05_1234);
    check("R1 no hit after reset", {31'b0, hit}, 32'h0);

    repeat (2) step();
    finish_run();
  end
endmodule